// File: doc/BRIEF.md
# Integer Execution Unit with Instruction Decode

This block is the arithmetic and logic stage of a simple 32-bit load/store core. It receives the full instruction word and the two source register values, then decodes the primary opcode and the function field. From these it forms the second operand, which is either the second register or the 16-bit immediate, extended as the operation needs. It returns the result word, a write-enable for the destination register and a signed-overflow flag. The whole path is combinational: outputs settle within the same cycle as the inputs.

A shared adder handles addition, subtraction and both forms of set-on-less-than. A parameterised barrel shifter does left shifts, zero-fill right shifts and sign-fill right shifts, with the shift count taken from the instruction. The block raises the overflow flag but does not trap. Exception handling belongs to the surrounding pipeline.

Top module: `alu_exec`

## Requirements
- R1: Fields are op = instr_i[31:26], funct = instr_i[5:0], shift count = instr_i[10:6] and immediate = instr_i[15:0]. An op/funct pair not listed in R2 to R10 gives we_o = 0, result_o = 0 and ovf_o = 0.
- R2: With op 0, funct octal 40 (ADD) and 41 (ADDU) give rs + rt modulo 2^32. Op octal 10 (ADDI) and 11 (ADDIU) give rs plus the sign-extended immediate.
- R3: ovf_o is 1 exactly when ADD, SUB or ADDI overflows as a signed operation. ADDU, SUBU, ADDIU and all other operations leave it at 0.
- R4: With op 0, funct octal 42 (SUB) and 43 (SUBU) give rs - rt modulo 2^32.
- R5: With op 0, funct octal 44, 45, 46 and 47 give rs & rt, rs | rt, rs ^ rt and ~(rs | rt).
- R6: Op octal 14, 15 and 16 give rs AND, OR and XOR with the zero-extended immediate.
- R7: Funct octal 52 (signed) and 53 (unsigned) write 1 if rs < rt, else 0. Op octal 12 (signed) and 13 (unsigned) compare rs with the sign-extended immediate in the same way.
- R8: Op octal 17 places the immediate in result bits [31:16] and zeros bits [15:0].
- R9: With op 0, funct 0 shifts rt left and funct 2 shifts rt right, each by the count, filling with zeros.
- R10: With op 0, funct 3 shifts rt right by the count and fills with copies of rt[31].
- R11: Every operation listed in R2 to R10 drives we_o = 1, including an ADD, SUB or ADDI that overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value, also the shift source |
| result_o | output | 32 | Computed result |
| we_o | output | 1 | Destination write-enable |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The assertions are immediate checks on settled combinational values. They assume that the instruction word and both operands hold stable while the outputs are evaluated. The bench meets this by changing inputs only on one clock edge and sampling on the opposite edge. Random stimulus draws mostly from the legal encodings and mixes in illegal ones. It biases operands toward the sign boundary, zero and all-ones, so that overflow, signed versus unsigned ordering and sign-filling shifts all occur.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned SHC_W   = 5;
  localparam int unsigned IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'o00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'o10;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'o11;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'o12;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'o13;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'o14;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'o15;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'o16;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'o17;

  localparam logic [FN_W-1:0] FN_SLL  = 6'o00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'o02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'o03;
  localparam logic [FN_W-1:0] FN_ADD  = 6'o40;
  localparam logic [FN_W-1:0] FN_ADDU = 6'o41;
  localparam logic [FN_W-1:0] FN_SUB  = 6'o42;
  localparam logic [FN_W-1:0] FN_SUBU = 6'o43;
  localparam logic [FN_W-1:0] FN_AND  = 6'o44;
  localparam logic [FN_W-1:0] FN_OR   = 6'o45;
  localparam logic [FN_W-1:0] FN_XOR  = 6'o46;
  localparam logic [FN_W-1:0] FN_NOR  = 6'o47;
  localparam logic [FN_W-1:0] FN_SLT  = 6'o52;
  localparam logic [FN_W-1:0] FN_SLTU = 6'o53;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLTU, OP_LUI, OP_SHIFT
  } alu_op_e;

  typedef enum logic [1:0] {SH_LEFT, SH_RIGHT, SH_ARITH} sh_mode_e;

  typedef struct packed {
    alu_op_e  op;
    sh_mode_e sh_mode;
    logic     use_imm;
    logic     imm_sext;
    logic     ovf_en;
    logic     we;
  } dec_s;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  output dec_s             dec_o
);
  always_comb begin
    dec_o          = '0;
    dec_o.op       = OP_NONE;
    dec_o.sh_mode  = SH_LEFT;
    dec_o.we       = 1'b1;
    if (opcode_i == OPC_RTYPE) begin
      unique case (funct_i)
        FN_SLL:  dec_o.op = OP_SHIFT;
        FN_SRL:  begin dec_o.op = OP_SHIFT; dec_o.sh_mode = SH_RIGHT; end
        FN_SRA:  begin dec_o.op = OP_SHIFT; dec_o.sh_mode = SH_ARITH; end
        FN_ADD:  begin dec_o.op = OP_ADD; dec_o.ovf_en = 1'b1; end
        FN_ADDU: dec_o.op = OP_ADD;
        FN_SUB:  begin dec_o.op = OP_SUB; dec_o.ovf_en = 1'b1; end
        FN_SUBU: dec_o.op = OP_SUB;
        FN_AND:  dec_o.op = OP_AND;
        FN_OR:   dec_o.op = OP_OR;
        FN_XOR:  dec_o.op = OP_XOR;
        FN_NOR:  dec_o.op = OP_NOR;
        FN_SLT:  dec_o.op = OP_SLT;
        FN_SLTU: dec_o.op = OP_SLTU;
        default: dec_o.we = 1'b0;
      endcase
    end else begin
      dec_o.use_imm = 1'b1;
      unique case (opcode_i)
        OPC_ADDI:  begin dec_o.op = OP_ADD; dec_o.imm_sext = 1'b1; dec_o.ovf_en = 1'b1; end
        OPC_ADDIU: begin dec_o.op = OP_ADD; dec_o.imm_sext = 1'b1; end
        OPC_SLTI:  begin dec_o.op = OP_SLT; dec_o.imm_sext = 1'b1; end
        OPC_SLTIU: begin dec_o.op = OP_SLTU; dec_o.imm_sext = 1'b1; end
        OPC_ANDI:  dec_o.op = OP_AND;
        OPC_ORI:   dec_o.op = OP_OR;
        OPC_XORI:  dec_o.op = OP_XOR;
        OPC_LUI:   dec_o.op = OP_LUI;
        default:   dec_o.we = 1'b0;
      endcase
    end
  end

  // R1: an unrecognised encoding must not enable a write
  always_comb begin
    if (dec_o.op == OP_NONE)
      p_none_no_we_r1: assert (!dec_o.we && !dec_o.ovf_en);
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o,
  output logic             lt_s_o,
  output logic             lt_u_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o  = full[WIDTH-1:0];
  assign ovf_o  = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
  assign lt_s_o = sum_o[WIDTH-1] ^ ovf_o;
  assign lt_u_o = ~full[WIDTH];  // no carry out of a - b means a < b

  // R7: equal operands are never less-than
  always_comb begin
    if (sub_i && (a_i == b_i))
      p_eq_not_lt_r7: assert (!lt_s_o && !lt_u_o);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned CNT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  sh_mode_e         mode_i,
  output logic [WIDTH-1:0] data_o
);
  logic             left;
  logic             fill;
  logic [WIDTH-1:0] rev_in;
  logic [WIDTH-1:0] rev_out;
  logic [WIDTH-1:0] stg [CNT_W+1];

  assign left = (mode_i == SH_LEFT);
  assign fill = (mode_i == SH_ARITH) & data_i[WIDTH-1];

  // left shifts reuse the right-shift network on bit-reversed data
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_in[i]  = data_i[WIDTH-1-i];
    assign rev_out[i] = stg[CNT_W][WIDTH-1-i];
  end

  assign stg[0] = left ? rev_in : data_i;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stg[k+1] = cnt_i[k] ? {{STEP{fill}}, stg[k][WIDTH-1:STEP]} : stg[k];
  end

  assign data_o = left ? rev_out : stg[CNT_W];

  always_comb begin
    if (cnt_i != '0) begin
      if (mode_i == SH_ARITH)
        p_sra_sign_fill_r10: assert (data_o[WIDTH-1] == data_i[WIDTH-1]);
      if (mode_i == SH_RIGHT)
        p_srl_zero_fill_r9: assert (data_o[WIDTH-1] == 1'b0);
      if (mode_i == SH_LEFT)
        p_sll_zero_fill_r9: assert (data_o[0] == 1'b0);
    end
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               we_o,
  output logic               ovf_o
);
  dec_s              dec;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] sh_out;
  logic              add_ovf;
  logic              lt_s;
  logic              lt_u;
  logic              use_sub;

  alu_decode u_decode (
    .opcode_i (instr_i[31:26]),
    .funct_i  (instr_i[5:0]),
    .dec_o    (dec)
  );

  assign imm     = instr_i[IMM_W-1:0];
  assign imm_ext = dec.imm_sext ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm}
                                : {{(DATA_W-IMM_W){1'b0}}, imm};
  assign opb     = dec.use_imm ? imm_ext : rt_val_i;
  assign use_sub = (dec.op == OP_SUB) || (dec.op == OP_SLT) || (dec.op == OP_SLTU);

  alu_addsub #(.WIDTH(DATA_W)) u_addsub (
    .a_i    (rs_val_i),
    .b_i    (opb),
    .sub_i  (use_sub),
    .sum_o  (sum),
    .ovf_o  (add_ovf),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  alu_shifter #(.WIDTH(DATA_W)) u_shifter (
    .data_i (rt_val_i),
    .cnt_i  (instr_i[6 +: CNT_W]),
    .mode_i (dec.sh_mode),
    .data_o (sh_out)
  );

  always_comb begin
    unique case (dec.op)
      OP_ADD, OP_SUB: result_o = sum;
      OP_AND:         result_o = rs_val_i & opb;
      OP_OR:          result_o = rs_val_i | opb;
      OP_XOR:         result_o = rs_val_i ^ opb;
      OP_NOR:         result_o = ~(rs_val_i | opb);
      OP_SLT:         result_o = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU:        result_o = {{(DATA_W-1){1'b0}}, lt_u};
      OP_LUI:         result_o = {imm, {(DATA_W-IMM_W){1'b0}}};
      OP_SHIFT:       result_o = sh_out;
      default:        result_o = '0;
    endcase
  end

  assign we_o  = dec.we;
  assign ovf_o = dec.ovf_en & add_ovf;

  always_comb begin
    if (!we_o)
      p_idle_quiet_r1: assert (result_o == '0 && !ovf_o);
    if (ovf_o)
      p_ovf_source_r3: assert (instr_i[31:26] == OPC_ADDI ||
                               (instr_i[31:26] == OPC_RTYPE &&
                                (instr_i[5:0] == FN_ADD || instr_i[5:0] == FN_SUB)));
    if (instr_i[31:26] == OPC_SLTI || instr_i[31:26] == OPC_SLTIU)
      p_slt_boolean_r7: assert (result_o[DATA_W-1:1] == '0 && we_o);
    if (instr_i[31:26] == OPC_LUI)
      p_lui_low_zero_r8: assert (result_o[DATA_W-IMM_W-1:0] == '0);
    if (instr_i[31:26] == OPC_ADDIU)
      p_no_overflow_r3: assert (!ovf_o);
  end
endmodule

// File: tb/alu_exec_tb.sv
module alu_exec_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_RAND     = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr, rs_v, rt_v;
  logic [31:0] res;
  logic        we, ovf;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_exec u_dut (
    .instr_i  (instr),
    .rs_val_i (rs_v),
    .rt_val_i (rt_v),
    .result_o (res),
    .we_o     (we),
    .ovf_o    (ovf)
  );

  function automatic string req_of(input logic [31:0] ins);
    logic [5:0] op = ins[31:26];
    logic [5:0] fn = ins[5:0];
    if (op == 6'o00) begin
      case (fn)
        6'o00, 6'o02: return "R9";
        6'o03:        return "R10";
        6'o40, 6'o41: return "R2/R3";
        6'o42, 6'o43: return "R4/R3";
        6'o44, 6'o45, 6'o46, 6'o47: return "R5";
        6'o52, 6'o53: return "R7";
        default:      return "R1";
      endcase
    end
    case (op)
      6'o10, 6'o11: return "R2/R3";
      6'o12, 6'o13: return "R7";
      6'o14, 6'o15, 6'o16: return "R6";
      6'o17: return "R8";
      default: return "R1";
    endcase
  endfunction

  // expected {we, ovf, result}
  function automatic logic [33:0] model(input logic [31:0] ins, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [5:0]  op = ins[31:26];
    logic [5:0]  fn = ins[5:0];
    logic [4:0]  sh = ins[10:6];
    logic [31:0] se = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] ze = {16'h0, ins[15:0]};
    logic [31:0] r = '0;
    logic        w = 1'b1, v = 1'b0;
    if (op == 6'o00) begin
      case (fn)
        6'o00: r = b << sh;
        6'o02: r = b >> sh;
        6'o03: r = $signed(b) >>> sh;
        6'o40: begin r = a + b; v = (a[31] == b[31]) && (r[31] != a[31]); end
        6'o41: r = a + b;
        6'o42: begin r = a - b; v = (a[31] != b[31]) && (r[31] != a[31]); end
        6'o43: r = a - b;
        6'o44: r = a & b;
        6'o45: r = a | b;
        6'o46: r = a ^ b;
        6'o47: r = ~(a | b);
        6'o52: r = {31'h0, $signed(a) < $signed(b)};
        6'o53: r = {31'h0, a < b};
        default: w = 1'b0;
      endcase
    end else begin
      case (op)
        6'o10: begin r = a + se; v = (a[31] == se[31]) && (r[31] != a[31]); end
        6'o11: r = a + se;
        6'o12: r = {31'h0, $signed(a) < $signed(se)};
        6'o13: r = {31'h0, a < se};
        6'o14: r = a & ze;
        6'o15: r = a | ze;
        6'o16: r = a ^ ze;
        6'o17: r = {ins[15:0], 16'h0};
        default: w = 1'b0;
      endcase
    end
    return {w, v, r};
  endfunction

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] sh);
    return {6'o00, 5'($urandom), 5'($urandom), 5'($urandom), sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'($urandom), 5'($urandom), imm};
  endfunction

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h7fff_ffff;
      2: return 32'h8000_0000;
      3: return 32'hffff_ffff;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [31:0] rand_instr();
    logic [5:0] fns [13] = '{6'o00, 6'o02, 6'o03, 6'o40, 6'o41, 6'o42, 6'o43,
                             6'o44, 6'o45, 6'o46, 6'o47, 6'o52, 6'o53};
    int sel = $urandom_range(0, 24);
    logic [15:0] imm = ($urandom_range(0, 3) == 0) ? 16'h8000 ^ 16'($urandom_range(0, 1))
                                                    : 16'($urandom);
    if (sel < 13) return enc_r(fns[sel], 5'($urandom));
    if (sel < 21) return enc_i(6'(6'o10 + sel - 13), imm);
    if (sel < 23) return enc_r(6'($urandom), 5'($urandom));  // mostly illegal funct
    return {6'($urandom), 26'($urandom)};
  endfunction

  task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    logic [33:0] exp;
    @(posedge clk);
    instr = ins; rs_v = a; rt_v = b;
    @(negedge clk);
    exp = model(ins, a, b);
    checks++;
    if ({we, ovf, res} !== exp) begin
      errors++;
      $display("FAIL %s instr=%h a=%h b=%h: got we=%b ovf=%b res=%h, exp we=%b ovf=%b res=%h",
               tag, ins, a, b, we, ovf, res, exp[33], exp[32], exp[31:0]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    instr = '0; rs_v = '0; rt_v = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R9/R11: all-zero word is a shift left by zero
    apply(32'h0, 32'h1234_5678, 32'hdead_beef, "R9 R11 zero word");
    // R2 R3: signed overflow on ADD, none on ADDU
    apply(enc_r(6'o40, 5'd0), 32'h7fff_ffff, 32'h1, "R3 add ovf");
    apply(enc_r(6'o41, 5'd0), 32'h7fff_ffff, 32'h1, "R3 addu no ovf");
    apply(enc_r(6'o40, 5'd0), 32'h8000_0000, 32'hffff_ffff, "R3 add neg ovf");
    // R4 R3: SUB overflow, SUBU none
    apply(enc_r(6'o42, 5'd0), 32'h8000_0000, 32'h1, "R4 R3 sub ovf");
    apply(enc_r(6'o43, 5'd0), 32'h8000_0000, 32'h1, "R4 subu");
    apply(enc_r(6'o42, 5'd0), 32'h0, 32'h8000_0000, "R4 R3 sub min ovf");
    // R2 R3 R11: ADDI sign extension, overflow keeps write
    apply(enc_i(6'o10, 16'hffff), 32'h5, 32'h0, "R2 addi minus one");
    apply(enc_i(6'o10, 16'h0001), 32'h7fff_ffff, 32'h0, "R3 R11 addi ovf");
    apply(enc_i(6'o11, 16'h0001), 32'h7fff_ffff, 32'h0, "R3 addiu no ovf");
    // R5
    apply(enc_r(6'o47, 5'd0), 32'h0f0f_0000, 32'h0000_00f0, "R5 nor");
    // R6: zero extension
    apply(enc_i(6'o14, 16'h8001), 32'hffff_ffff, 32'h0, "R6 andi");
    apply(enc_i(6'o15, 16'hf000), 32'h0, 32'h0, "R6 ori");
    // R7: signed vs unsigned order
    apply(enc_r(6'o52, 5'd0), 32'hffff_ffff, 32'h1, "R7 slt neg");
    apply(enc_r(6'o53, 5'd0), 32'hffff_ffff, 32'h1, "R7 sltu");
    apply(enc_i(6'o13, 16'hffff), 32'h7, 32'h0, "R7 sltiu sext");
    apply(enc_i(6'o12, 16'h8000), 32'h0, 32'h0, "R7 slti");
    apply(enc_r(6'o52, 5'd0), 32'h5, 32'h5, "R7 slt equal");
    // R8
    apply(enc_i(6'o17, 16'ha5c3), 32'hffff_ffff, 32'h0, "R8 lui");
    // R9 R10: shifts
    apply(enc_r(6'o03, 5'd31), 32'h0, 32'h8000_0000, "R10 sra 31");
    apply(enc_r(6'o03, 5'd4), 32'h0, 32'h7000_0000, "R10 sra pos");
    apply(enc_r(6'o02, 5'd31), 32'h0, 32'h8000_0000, "R9 srl 31");
    apply(enc_r(6'o00, 5'd31), 32'h0, 32'hffff_ffff, "R9 sll 31");
    // R1: illegal encodings
    apply(enc_r(6'o01, 5'd3), 32'hffff_ffff, 32'hffff_ffff, "R1 bad funct");
    apply({6'o77, 26'h3ff_ffff}, 32'h7fff_ffff, 32'h1, "R1 bad opcode");
    apply(enc_r(6'o50, 5'd0), 32'h1, 32'h2, "R1 gap funct");

    for (int i = 0; i < N_RAND; i++) begin
      logic [31:0] ins = rand_instr();
      apply(ins, pick_val(), pick_val(), req_of(ins));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule